// File: doc/BRIEF.md
# Ping-pong OUT endpoint receive buffer

This block buffers received data for a single OUT endpoint of a device-side serial bus controller. It uses two packet banks that are filled in strict alternation. Upstream logic has already decoded the packet and checked it. It delivers the payload as a byte stream framed by a start strobe and by either an end strobe or an abort strobe. For every packet that ends normally, the block answers with a handshake choice: acknowledge, not-ready or stall.

Firmware sees the following for each bank:
- a full flag,
- a byte count,
- a combinational read port.

Firmware releases a bank with a clear strobe. Clears must alternate, starting with bank 0, because two full flags do not show which bank was filled first. The block keeps a pointer to the bank that is due to be cleared next. A clear aimed at the other bank is ignored and sets a sticky order-error bit. While a force-stall input is high, every packet is answered with a stall. An interrupt line is high whenever any bank is full.

The byte stream uses valid/ready. `rx_ready` is high only between a start strobe and the end or abort strobe that closes the packet. Upstream must hold `rx_valid` low outside that window. While ready is high, the block never applies back-pressure; it takes one byte on every cycle where `rx_valid` is high. Start, end and abort arrive in cycles that carry no byte.

Top module: `pp_out_ep`

## Requirements
- R1: Acknowledged payloads go into bank 0, then bank 1, then bank 0 again, and so on. The write pointer moves only when a packet is acknowledged.
- R2: When a packet is accepted, the cycle after the end strobe shows all of the following:
  - `hs_valid` is high for exactly one cycle with `hs_code` = 2'b01 (acknowledge);
  - the bank's bit in `bank_full` is set (bit 0 is bank 0);
  - the bank's count equals the number of bytes received;
  - byte k of the payload can be read at `rd_addr` = k of that bank.
- R3: `irq` is high exactly while at least one bit of `bank_full` is set.
- R4: Clearing a full bank releases it. After bank 0 is cleared, the third payload is accepted into bank 0.
- R5: While `force_stall` is high in the end-strobe cycle, the handshake is 2'b11 (stall), no flag is set and the write pointer does not move.
- R6: If the bank next in sequence is full when the start strobe arrives, the packet is answered with 2'b10 (not-ready). Its bytes are not written, so the stored contents of that bank are unchanged, and the write pointer does not move.
- R7: A packet closed by the abort strobe produces no handshake, sets no flag and leaves the write pointer unchanged.
- R8: `next_clear` shows the bank expected to be cleared next (0 after reset). A clear strobe on `fw_clr` aimed at that bank, while the bank is full, drops its flag in the next cycle and flips `next_clear`.
- R9: A clear strobe aimed at the bank that is not `next_clear` leaves both flags unchanged. It sets `order_err`, which stays set until reset.
- R10: A payload longer than 64 bytes is answered with 2'b10, sets no flag and leaves the write pointer unchanged. A payload of exactly 64 bytes is accepted.
- R11: A zero-length payload is acknowledged and records a count of 0.
- R12: After reset the following hold:
  - `bank_full` = 0, `irq` = 0 and `order_err` = 0;
  - `next_clear` = 0 and the write pointer is at bank 0;
  - `rx_ready` = 0 and `hs_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start | input | 1 | Opens a packet |
| rx_valid | input | 1 | Payload byte present |
| rx_ready | output | 1 | High while a packet is open |
| rx_data | input | 8 | Payload byte |
| pkt_end | input | 1 | Closes a packet normally |
| pkt_abort | input | 1 | Closes a packet that failed validation |
| hs_valid | output | 1 | One-cycle handshake strobe |
| hs_code | output | 2 | 01 acknowledge, 10 not-ready, 11 stall |
| force_stall | input | 1 | Firmware stall request |
| fw_clr | input | 2 | Per-bank clear strobes |
| bank_full | output | 2 | Per-bank full flags |
| bank0_count | output | 7 | Byte count of bank 0 |
| bank1_count | output | 7 | Byte count of bank 1 |
| rd_bank | input | 1 | Read port bank select |
| rd_addr | input | 6 | Read port byte address |
| rd_data | output | 8 | Read port data, combinational |
| next_clear | output | 1 | Bank expected to be cleared next |
| order_err | output | 1 | Sticky out-of-order clear indication |
| irq | output | 1 | High while any bank is full |

## Verification
The handshake, the full flag, the byte count and the interrupt are all registered by the clock edge that samples the end strobe, so each is due one cycle after that strobe. A clear strobe changes `bank_full`, `next_clear` and `order_err` one cycle after it is sampled. The read port is combinational and reflects the address in the same cycle. The bench drives every input on the falling edge and samples on the next falling edge after the edge that consumes the stimulus. It samples `rd_data` a short delay after changing the address, well away from any rising edge.

// File: rtl/pp_out_pkg.sv
package pp_out_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_code_e;
endpackage

// File: rtl/pp_rx_ctrl.sv
module pp_rx_ctrl
  import pp_out_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_BYTES = 64,
  parameter int CNT_W      = $clog2(BANK_BYTES + 1),
  parameter int ADDR_W     = $clog2(BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              pkt_end,
  input  logic              pkt_abort,
  input  logic              force_stall,
  input  logic [1:0]        full,
  output logic              rx_ready,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic [CNT_W-1:0]  commit_cnt,
  output logic              hs_valid,
  output logic [1:0]        hs_code
);
  logic             in_pkt_q, busy_q, ovf_q, bank_q, hs_valid_q;
  logic [CNT_W-1:0] cnt_q;
  hs_code_e         hs_code_q, verdict;
  logic             room;

  assign room = cnt_q < CNT_W'(BANK_BYTES);

  always_comb begin
    if (force_stall)          verdict = HS_STALL;
    else if (busy_q || ovf_q) verdict = HS_NAK;
    else                      verdict = HS_ACK;
  end

  assign rx_ready   = in_pkt_q;
  assign wr_en      = in_pkt_q & rx_valid & ~busy_q & room;
  assign wr_bank    = bank_q;
  assign wr_addr    = cnt_q[ADDR_W-1:0];
  assign wr_data    = rx_data;
  assign commit     = in_pkt_q & pkt_end & (verdict == HS_ACK);
  assign commit_cnt = cnt_q;
  assign hs_valid   = hs_valid_q;
  assign hs_code    = hs_code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q   <= 1'b0;
      busy_q     <= 1'b0;
      ovf_q      <= 1'b0;
      bank_q     <= 1'b0;
      cnt_q      <= '0;
      hs_valid_q <= 1'b0;
      hs_code_q  <= HS_NONE;
    end else begin
      hs_valid_q <= 1'b0;
      if (pkt_start) begin
        in_pkt_q <= 1'b1;
        busy_q   <= full[bank_q];
        ovf_q    <= 1'b0;
        cnt_q    <= '0;
      end else if (in_pkt_q) begin
        if (pkt_end) begin
          in_pkt_q   <= 1'b0;
          hs_valid_q <= 1'b1;
          hs_code_q  <= verdict;
          if (commit) bank_q <= ~bank_q;
        end else if (pkt_abort) begin
          in_pkt_q <= 1'b0;
        end else if (rx_valid) begin
          if (room) cnt_q <= cnt_q + 1'b1;
          else      ovf_q <= 1'b1;
        end
      end
    end
  end

  // R1: only an acknowledge moves the write pointer
  p_ack_moves_ptr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid_q && hs_code_q == HS_ACK) |-> (bank_q != $past(bank_q)));
  // R6 R7 R10: refusals keep the pointer
  p_refusal_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid_q && hs_code_q != HS_ACK) |-> (bank_q == $past(bank_q)));
  // R5
  p_stall_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid_q && $past(force_stall)) |-> (hs_code_q == HS_STALL));
  // R2: handshake is a single-cycle strobe
  p_hs_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid_q |=> !hs_valid_q);
  // R7: abort closes the packet without a handshake
  p_abort_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt_q && pkt_abort && !pkt_end && !pkt_start) |=> (!hs_valid_q && !in_pkt_q));
endmodule

// File: rtl/pp_bank_store.sv
module pp_bank_store
  import pp_out_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_BYTES = 64,
  parameter int CNT_W      = $clog2(BANK_BYTES + 1),
  parameter int ADDR_W     = $clog2(BANK_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_bank,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       commit,
  input  logic                       commit_bank,
  input  logic [CNT_W-1:0]           commit_cnt,
  input  logic                       rd_bank,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_BANKS*CNT_W-1:0] counts
);
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [BANK_BYTES];
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_bank == 1'(b)) mem_q[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                            cnt_q <= '0;
      else if (commit && commit_bank == 1'(b)) cnt_q <= commit_cnt;
    end

    assign bank_rd[b]                 = mem_q[rd_addr];
    assign counts[b*CNT_W +: CNT_W]   = cnt_q;

    // R2: a recorded count never exceeds the bank size
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BANK_BYTES));
  end

  assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/pp_fw_seq.sv
module pp_fw_seq
  import pp_out_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic       commit_bank,
  input  logic [1:0] fw_clr,
  output logic [1:0] full,
  output logic       next_clear,
  output logic       order_err
);
  logic [1:0] full_q, clr_ok, set_v, due;
  logic       next_q, err_q, wrong;

  assign due   = next_q ? 2'b10 : 2'b01;
  assign set_v = commit ? (commit_bank ? 2'b10 : 2'b01) : 2'b00;
  assign clr_ok = fw_clr & due & full_q;
  assign wrong  = |(fw_clr & ~due);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= '0;
      next_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      full_q <= (full_q & ~clr_ok) | set_v;
      if (|clr_ok) next_q <= ~next_q;
      if (wrong)   err_q  <= 1'b1;
    end
  end

  assign full       = full_q;
  assign next_clear = next_q;
  assign order_err  = err_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    // R2: a flag rises only on an acknowledged commit into that bank
    p_set_on_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q[b]) |-> $past(commit && commit_bank == 1'(b)));
    // R8: a flag falls only on a clear of the bank that was due
    p_clear_in_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(full_q[b]) |-> ($past(fw_clr[b]) && $past(next_q) == 1'(b)));
  end

  // R9: order error is sticky
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/pp_out_ep.sv
module pp_out_ep
  import pp_out_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_BYTES = 64,
  localparam int CNT_W     = $clog2(BANK_BYTES + 1),
  localparam int ADDR_W    = $clog2(BANK_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              pkt_end,
  input  logic              pkt_abort,
  output logic              hs_valid,
  output logic [1:0]        hs_code,
  input  logic              force_stall,
  input  logic [1:0]        fw_clr,
  output logic [1:0]        bank_full,
  output logic [CNT_W-1:0]  bank0_count,
  output logic [CNT_W-1:0]  bank1_count,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              next_clear,
  output logic              order_err,
  output logic              irq
);
  logic                       wr_en, wr_bank, commit;
  logic [ADDR_W-1:0]          wr_addr;
  logic [DATA_W-1:0]          wr_data;
  logic [CNT_W-1:0]           commit_cnt;
  logic [1:0]                 full;
  logic [NUM_BANKS*CNT_W-1:0] counts;

  pp_rx_ctrl #(.DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .rx_valid(rx_valid), .rx_data(rx_data),
    .pkt_end(pkt_end), .pkt_abort(pkt_abort), .force_stall(force_stall), .full(full),
    .rx_ready(rx_ready), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_cnt(commit_cnt), .hs_valid(hs_valid), .hs_code(hs_code)
  );

  pp_bank_store #(.DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .commit_bank(wr_bank), .commit_cnt(commit_cnt),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data), .counts(counts)
  );

  pp_fw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_bank(wr_bank), .fw_clr(fw_clr),
    .full(full), .next_clear(next_clear), .order_err(order_err)
  );

  assign bank_full   = full;
  assign bank0_count = counts[0 +: CNT_W];
  assign bank1_count = counts[CNT_W +: CNT_W];
  assign irq         = |full;

  // R6: bytes never land in a bank that firmware still owns
  p_no_write_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full[wr_bank]);
  // R3: interrupt tracks the flags after each edge
  p_irq_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(commit));
endmodule

// File: tb/pp_out_ep_tb.sv
module pp_out_ep_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pkt_start = 0, rx_valid = 0, pkt_end = 0, pkt_abort = 0, force_stall = 0;
  logic [7:0] rx_data = '0;
  logic [1:0] fw_clr = '0;
  logic       rd_bank = 0;
  logic [5:0] rd_addr = '0;
  logic       rx_ready, hs_valid, next_clear, order_err, irq;
  logic [1:0] hs_code, bank_full;
  logic [6:0] bank0_count, bank1_count;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  pp_out_ep dut_i (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .pkt_end(pkt_end), .pkt_abort(pkt_abort), .hs_valid(hs_valid),
    .hs_code(hs_code), .force_stall(force_stall), .fw_clr(fw_clr), .bank_full(bank_full),
    .bank0_count(bank0_count), .bank1_count(bank1_count), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_data(rd_data), .next_clear(next_clear), .order_err(order_err), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Drives one packet; returns at the falling edge after the closing strobe.
  task automatic send(input int n, input int base, input bit abort_it);
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1;
      rx_data  = 8'(base + i);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    if (abort_it) pkt_abort = 1'b1;
    else          pkt_end   = 1'b1;
    @(negedge clk);
    pkt_abort = 1'b0;
    pkt_end   = 1'b0;
  endtask

  task automatic clear(input logic [1:0] m);
    fw_clr = m;
    @(negedge clk);
    fw_clr = 2'b00;
  endtask

  task automatic rd_chk(input string req, input bit b, input int a, input int exp);
    rd_bank = b;
    rd_addr = 6'(a);
    #1;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic t_reset();
    chk("R12 flags", int'(bank_full), 0);
    chk("R12 irq", int'(irq), 0);
    chk("R12 next_clear", int'(next_clear), 0);
    chk("R12 order_err", int'(order_err), 0);
    chk("R12 rx_ready", int'(rx_ready), 0);
    chk("R12 hs_valid", int'(hs_valid), 0);
  endtask

  task automatic t_alternate();
    send(5, 8'h10, 1'b0);
    chk("R2 hs_valid", int'(hs_valid), 1);
    chk("R2 ack", int'(hs_code), 1);
    chk("R1 bank0 full", int'(bank_full), 1);
    chk("R2 count0", int'(bank0_count), 5);
    chk("R3 irq on", int'(irq), 1);
    rd_chk("R2 byte0", 1'b0, 0, 8'h10);
    rd_chk("R2 byte4", 1'b0, 4, 8'h14);
    @(negedge clk);
    chk("R2 hs one cycle", int'(hs_valid), 0);
    send(3, 8'h40, 1'b0);
    chk("R1 ack second", int'(hs_code), 1);
    chk("R1 bank1 full", int'(bank_full), 3);
    chk("R2 count1", int'(bank1_count), 3);
    rd_chk("R2 bank1 byte2", 1'b1, 2, 8'h42);
  endtask

  task automatic t_nak_full();
    send(4, 8'hA0, 1'b0);
    chk("R6 nak", int'(hs_code), 2);
    chk("R6 flags kept", int'(bank_full), 3);
    rd_chk("R6 bank0 intact", 1'b0, 0, 8'h10);
    chk("R6 count kept", int'(bank0_count), 5);
  endtask

  task automatic t_order();
    clear(2'b10);
    chk("R9 wrong clear ignored", int'(bank_full), 3);
    chk("R9 order_err set", int'(order_err), 1);
    chk("R8 next still 0", int'(next_clear), 0);
    clear(2'b01);
    chk("R8 bank0 released", int'(bank_full), 2);
    chk("R8 next flips", int'(next_clear), 1);
    send(2, 8'h70, 1'b0);
    chk("R4 third accepted", int'(hs_code), 1);
    chk("R4 third in bank0", int'(bank_full), 3);
    chk("R4 count0", int'(bank0_count), 2);
    rd_chk("R4 bank0 data", 1'b0, 1, 8'h71);
    clear(2'b10);
    chk("R8 bank1 released", int'(bank_full), 1);
    chk("R3 irq held", int'(irq), 1);
    clear(2'b01);
    chk("R3 irq off", int'(irq), 0);
    chk("R9 order_err sticky", int'(order_err), 1);
  endtask

  task automatic t_stall();
    force_stall = 1'b1;
    send(3, 8'h55, 1'b0);
    chk("R5 stall", int'(hs_code), 3);
    chk("R5 no flag", int'(bank_full), 0);
    force_stall = 1'b0;
    send(1, 8'h66, 1'b0);
    chk("R5 ptr kept ack", int'(hs_code), 1);
    chk("R5 lands in bank1", int'(bank_full), 2);
    chk("R5 count1", int'(bank1_count), 1);
    clear(2'b10);
  endtask

  task automatic t_abort();
    send(3, 8'h33, 1'b1);
    chk("R7 no handshake", int'(hs_valid), 0);
    chk("R7 no flag", int'(bank_full), 0);
    send(0, 0, 1'b0);
    chk("R11 zero ack", int'(hs_code), 1);
    chk("R7 ptr kept bank0", int'(bank_full), 1);
    chk("R11 zero count", int'(bank0_count), 0);
    clear(2'b01);
  endtask

  task automatic t_overflow();
    send(65, 0, 1'b0);
    chk("R10 nak", int'(hs_code), 2);
    chk("R10 no flag", int'(bank_full), 0);
    send(64, 0, 1'b0);
    chk("R10 full size ack", int'(hs_code), 1);
    chk("R10 bank1 full", int'(bank_full), 2);
    chk("R10 count 64", int'(bank1_count), 64);
    rd_chk("R10 last byte", 1'b1, 63, 63);
    clear(2'b10);
    chk("R10 released", int'(bank_full), 0);
  endtask

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alternate();
    t_nak_full();
    t_order();
    t_stall();
    t_abort();
    t_overflow();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule